// File: doc/BRIEF.md
# Slave Frame Sync Monitor

This block sits on the receiving side of a serial audio link whose frame sync (FS) and bit clock come from an external master. It synchronizes the incoming FS line, finds frame starts on the transition into the active level, and runs a bit-position counter over the programmed frame length. It uses that counter to police the master: it reports an FS edge that arrives while a frame is still running, and it reports an FS edge that is missing when a frame ends.

Downstream shift logic uses the one-cycle `frame_start` strobe to align its data. Two sticky flags, one for early and one for late frame sync, hold each error until software or a controller pulses `err_clr`. After any error the monitor stops tracking and waits for a fresh FS edge, then starts counting again from it.

Top module: `fs_slave_monitor`

## Requirements
- R1: The expected frame length in bit ticks is `frame_len_field + 1`. Any field value from 7 to 255 is accepted as it is, with no power-of-two restriction.
- R2: A `frame_len_field` value below 7 is treated as 7, so the shortest policed frame is 8 bit ticks.
- R3: FS passes through a two-stage synchronizer clocked by `clk`, so a tick sees FS as it was driven two `clk` cycles earlier. A frame start is the first tick at which the synchronized FS is active after a tick at which it was inactive. `fs_active_low` = 0 makes high the active level, and `fs_active_low` = 1 makes low the active level.
- R4: While `en` is low, no strobe and no error is produced. After `en` rises, an FS that is already active does not count as an edge. The monitor begins only at the first inactive-to-active transition.
- R5: `frame_start` is high for exactly one `clk` cycle. It is registered on the tick that carries bit 0 of a frame.
- R6: An active edge at any tick other than the expected one, while a frame is being tracked, sets `err_anticipated`. That edge does not produce a frame start.
- R7: If no active edge is seen at the tick where it is expected, `err_late` is set.
- R8: With `fs_lead` = 0 the expected edge is on bit 0, and the strobe comes on the edge's tick. With `fs_lead` = 1 the expected edge is on the last bit of the previous frame, and the strobe comes one tick after the edge.
- R9: After either error the monitor ignores FS until the next active edge. That edge restarts counting and strobing as at enable.
- R10: Each error flag stays set until a cycle with `err_clr` high. If a set and a clear land in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Monitor enable; low forces the hunting state |
| bit_tick | input | 1 | One-cycle bit-clock enable; one pulse per serial bit |
| fs_in | input | 1 | Frame sync from the external master (asynchronous) |
| fs_active_low | input | 1 | 1: FS active level is low; 0: active level is high |
| fs_lead | input | 1 | 1: FS edge one bit before bit 0; 0: FS edge on bit 0 |
| frame_len_field | input | 8 | Frame length minus one, in bit ticks |
| err_clr | input | 1 | Clears both error flags (a set in the same cycle wins) |
| frame_start | output | 1 | One-cycle strobe marking bit 0 of a tracked frame |
| err_anticipated | output | 1 | Sticky flag: FS edge arrived before the frame ended |
| err_late | output | 1 | Sticky flag: FS edge missing when the frame ended |

## Verification
A wrong bit position or a stuck tracking state appears at the ports within one frame. The strobe drifts off the FS edge, or one of the sticky flags rises on the first tick where the expected edge and the counter disagree. The bench's reference model predicts every output on every clock, so a one-tick slip in the offset handling or the length clamp shows as a mismatch on the very tick it occurs. A flag that fails to hold or to clear shows in the cycle after the set or the clear.

// File: rtl/fs_mon_pkg.sv
package fs_mon_pkg;

   typedef enum logic {
      TRK_HUNT  = 1'b0,
      TRK_LOCK  = 1'b1
   } trk_state_e;

   localparam int unsigned FLAG_EARLY = 0;
   localparam int unsigned FLAG_LATE  = 1;
   localparam int unsigned FLAG_COUNT = 2;

endpackage

// File: rtl/fs_sync_edge.sv
module fs_sync_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic tick,
   input  logic fs_raw,
   input  logic active_low,
   output logic edge_seen
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_act_q;
   logic                   act_now;

   generate
      if (SYNC_STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[0], fs_raw};
         end
      end else begin : g_deep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], fs_raw};
         end
      end
   endgenerate

   assign act_now = sync_q[SYNC_STAGES-1] ^ active_low;

   // previous active level, forced high while disabled so that a level
   // already present at enable is not mistaken for a transition
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     last_act_q <= 1'b1;
      else if (!en)   last_act_q <= 1'b1;
      else if (tick)  last_act_q <= act_now;
   end

   assign edge_seen = act_now & ~last_act_q;

endmodule

// File: rtl/fs_frame_tracker.sv
module fs_frame_tracker
   import fs_mon_pkg::*;
#(
   parameter int unsigned LEN_W   = 8,
   parameter int unsigned MIN_LEN = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             edge_seen,
   input  logic             lead_mode,
   input  logic [LEN_W-1:0] len_field,
   output logic             start_q,
   output logic             set_early,
   output logic             set_late
);

   localparam logic [LEN_W-1:0] MIN_LAST = LEN_W'(MIN_LEN - 1);

   trk_state_e       state_q;
   logic [LEN_W-1:0] pos_q;
   logic [LEN_W-1:0] last_pos;
   logic [LEN_W-1:0] exp_pos;
   logic [LEN_W-1:0] pos_after_exp;
   logic [LEN_W-1:0] pos_next;
   logic             at_exp;
   logic             live;

   assign last_pos      = (len_field < MIN_LAST) ? MIN_LAST : len_field;
   assign exp_pos       = lead_mode ? last_pos : '0;
   assign pos_after_exp = (exp_pos == last_pos) ? '0 : exp_pos + 1'b1;
   assign pos_next      = (pos_q == last_pos) ? '0 : pos_q + 1'b1;
   assign at_exp        = (pos_q == exp_pos);
   assign live          = en & tick & (state_q == TRK_LOCK);

   assign set_early = live &  edge_seen & ~at_exp;
   assign set_late  = live & ~edge_seen &  at_exp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TRK_HUNT;
         pos_q   <= '0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (!en) begin
            state_q <= TRK_HUNT;
            pos_q   <= '0;
         end else if (tick) begin
            if (state_q == TRK_HUNT) begin
               if (edge_seen) begin
                  state_q <= TRK_LOCK;
                  pos_q   <= pos_after_exp;
                  start_q <= (exp_pos == '0);
               end
            end else if (set_early || set_late) begin
               state_q <= TRK_HUNT;
            end else begin
               start_q <= (pos_q == '0);
               pos_q   <= pos_next;
            end
         end
      end
   end

endmodule

// File: rtl/fs_err_flags.sv
module fs_err_flags #(
   parameter int unsigned N_FLAGS = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_FLAGS-1:0] set_i,
   input  logic               clr_i,
   output logic [N_FLAGS-1:0] flag_q
);

   generate
      for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flag_q[g] <= 1'b0;
            else if (set_i[g])  flag_q[g] <= 1'b1;
            else if (clr_i)     flag_q[g] <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/fs_slave_monitor.sv
module fs_slave_monitor
   import fs_mon_pkg::*;
#(
   parameter int unsigned LEN_W       = 8,
   parameter int unsigned MIN_LEN     = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             bit_tick,
   input  logic             fs_in,
   input  logic             fs_active_low,
   input  logic             fs_lead,
   input  logic [LEN_W-1:0] frame_len_field,
   input  logic             err_clr,
   output logic             frame_start,
   output logic             err_anticipated,
   output logic             err_late
);

   generate
      if (LEN_W < 3) begin : g_bad_len_w
         $error("LEN_W must hold at least the minimum frame length");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (MIN_LEN < 2 || MIN_LEN > (1 << LEN_W)) begin : g_bad_min
         $error("MIN_LEN out of range for LEN_W");
      end
   endgenerate

   logic                  edge_seen;
   logic                  set_early;
   logic                  set_late;
   logic [FLAG_COUNT-1:0] set_vec;
   logic [FLAG_COUNT-1:0] flag_vec;

   fs_sync_edge #(
      .SYNC_STAGES(SYNC_STAGES)
   ) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .tick      (bit_tick),
      .fs_raw    (fs_in),
      .active_low(fs_active_low),
      .edge_seen (edge_seen)
   );

   fs_frame_tracker #(
      .LEN_W  (LEN_W),
      .MIN_LEN(MIN_LEN)
   ) i_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .tick     (bit_tick),
      .edge_seen(edge_seen),
      .lead_mode(fs_lead),
      .len_field(frame_len_field),
      .start_q  (frame_start),
      .set_early(set_early),
      .set_late (set_late)
   );

   assign set_vec[FLAG_EARLY] = set_early;
   assign set_vec[FLAG_LATE]  = set_late;

   fs_err_flags #(
      .N_FLAGS(FLAG_COUNT)
   ) i_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec),
      .clr_i (err_clr),
      .flag_q(flag_vec)
   );

   assign err_anticipated = flag_vec[FLAG_EARLY];
   assign err_late        = flag_vec[FLAG_LATE];

endmodule

// File: rtl/fs_slave_monitor_chk.sv
module fs_slave_monitor_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic bit_tick,
   input logic err_clr,
   input logic set_early,
   input logic set_late,
   input logic frame_start,
   input logic err_anticipated,
   input logic err_late
);

   assert_no_start_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !frame_start);

   assert_start_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> !frame_start);

   assert_early_not_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_early |=> (err_anticipated && !frame_start));

   assert_late_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set_late |=> err_late);

   assert_one_error_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_early && set_late));

   assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_anticipated && !err_clr) |=> err_anticipated);

   assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && !set_late) |=> !err_late);

endmodule

bind fs_slave_monitor fs_slave_monitor_chk i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .en             (en),
   .bit_tick       (bit_tick),
   .err_clr        (err_clr),
   .set_early      (set_early),
   .set_late       (set_late),
   .frame_start    (frame_start),
   .err_anticipated(err_anticipated),
   .err_late       (err_late)
);

// File: tb/test_fs_slave_monitor.sv
module test_fs_slave_monitor;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       bit_tick = 1'b0;
   logic       fs_in = 1'b0;
   logic       fs_active_low = 1'b0;
   logic       fs_lead = 1'b0;
   logic [7:0] frame_len_field = 8'd15;
   logic       err_clr = 1'b0;
   logic       frame_start;
   logic       err_anticipated;
   logic       err_late;

   int    n_chk = 0;
   int    n_bad = 0;
   int    n_starts = 0;
   int    n_ea_hi = 0;
   string cur_tag = "R5";

   // reference model state
   logic m_d1 = 1'b0, m_d2 = 1'b0, m_prev = 1'b1, m_hunt = 1'b1;
   int   m_pos = 0;
   logic m_start = 1'b0, m_ea = 1'b0, m_el = 1'b0;

   always #5 clk = ~clk;

   fs_slave_monitor i_fs_slave_monitor (
      .clk            (clk),
      .rst_n          (rst_n),
      .en             (en),
      .bit_tick       (bit_tick),
      .fs_in          (fs_in),
      .fs_active_low  (fs_active_low),
      .fs_lead        (fs_lead),
      .frame_len_field(frame_len_field),
      .err_clr        (err_clr),
      .frame_start    (frame_start),
      .err_anticipated(err_anticipated),
      .err_late       (err_late)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      logic act, edg, ms, se, sl;
      int   lm1, ex;
      if (!rst_n) begin
         m_d1 = 0; m_d2 = 0; m_prev = 1; m_hunt = 1; m_pos = 0;
         m_start = 0; m_ea = 0; m_el = 0;
      end else begin
         act = m_d2 ^ fs_active_low;
         m_d2 = m_d1; m_d1 = fs_in;
         ms = 0; se = 0; sl = 0;
         if (!en) begin
            m_hunt = 1; m_prev = 1; m_pos = 0;
         end else if (bit_tick) begin
            edg = act && !m_prev; m_prev = act;
            lm1 = (frame_len_field < 7) ? 7 : int'(frame_len_field);
            ex  = fs_lead ? lm1 : 0;
            if (m_hunt) begin
               if (edg) begin
                  m_hunt = 0; m_pos = (ex == lm1) ? 0 : ex + 1; ms = (ex == 0);
               end
            end else if (edg && m_pos != ex) begin
               se = 1; m_hunt = 1;
            end else if (!edg && m_pos == ex) begin
               sl = 1; m_hunt = 1;
            end else begin
               ms = (m_pos == 0); m_pos = (m_pos == lm1) ? 0 : m_pos + 1;
            end
         end
         m_start = ms;
         m_ea = se ? 1'b1 : (err_clr ? 1'b0 : m_ea);
         m_el = sl ? 1'b1 : (err_clr ? 1'b0 : m_el);
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check(frame_start == m_start, {cur_tag, " R5 strobe"}, frame_start, m_start);
         check(err_anticipated == m_ea, {cur_tag, " R6 early flag"}, err_anticipated, m_ea);
         check(err_late == m_el, {cur_tag, " R7 late flag"}, err_late, m_el);
         if (frame_start) n_starts++;
         if (err_anticipated) n_ea_hi++;
      end
   end

   task automatic slot(input logic lvl);
      @(posedge clk); #2;
      bit_tick = 1'b1;
      fs_in    = lvl ^ fs_active_low;
      @(posedge clk); #2;
      bit_tick = 1'b0;
   endtask

   task automatic frame(input int nbits, input int hi);
      for (int b = 0; b < nbits; b++) slot(b < hi);
   endtask

   task automatic setup(input string tag, input logic pol, input logic lead, input int len);
      @(posedge clk); #2;
      en = 1'b0; err_clr = 1'b1;
      fs_active_low = pol; fs_lead = lead; frame_len_field = 8'(len);
      fs_in = pol;
      repeat (4) @(posedge clk);
      #2 err_clr = 1'b0; en = 1'b1;
      cur_tag = tag; n_starts = 0; n_ea_hi = 0;
   endtask

   initial begin
      #200000000;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check(frame_start == 0, "R5 reset strobe", frame_start, 0);
      check(err_anticipated == 0, "R6 reset flag", err_anticipated, 0);
      check(err_late == 0, "R7 reset flag", err_late, 0);
      rst_n = 1'b1;

      // R1: 16-bit frames, edge on bit 0, active high
      setup("R1", 1'b0, 1'b0, 15);
      repeat (4) frame(16, 8);
      check(n_starts == 4, "R1 frame starts", n_starts, 4);
      check(err_anticipated == 0 && err_late == 0, "R1 no error", err_anticipated + err_late, 0);

      // R1: non power-of-two length (12 bits) is accepted
      setup("R1", 1'b0, 1'b0, 11);
      repeat (4) frame(12, 6);
      check(n_starts == 4, "R1 length 12 starts", n_starts, 4);
      check(err_late == 0, "R1 length 12 no late", err_late, 0);

      // R8: edge one bit ahead of bit 0
      setup("R8", 1'b0, 1'b1, 15);
      repeat (4) frame(16, 1);
      check(n_starts == 4, "R8 lead starts", n_starts, 4);
      check(err_anticipated == 0 && err_late == 0, "R8 no error", err_anticipated + err_late, 0);

      // R3: active-low polarity
      setup("R3", 1'b1, 1'b0, 15);
      repeat (3) frame(16, 8);
      check(n_starts == 3, "R3 active-low starts", n_starts, 3);
      check(err_late == 0, "R3 no late", err_late, 0);

      // R2: field 3 behaves as 7 (8-bit frames)
      setup("R2", 1'b0, 1'b0, 3);
      repeat (3) frame(8, 4);
      check(n_starts == 3, "R2 clamp starts", n_starts, 3);
      check(err_anticipated == 0 && err_late == 0, "R2 no error", err_anticipated + err_late, 0);

      // R4: FS already active at enable is not an edge
      setup("R4", 1'b0, 1'b0, 15);
      @(posedge clk); #2 en = 1'b0; fs_in = 1'b1;
      repeat (4) @(posedge clk);
      #2 en = 1'b1;
      repeat (6) slot(1'b1);
      check(n_starts == 0, "R4 no start on level", n_starts, 0);
      check(err_anticipated == 0 && err_late == 0, "R4 no error", err_anticipated + err_late, 0);

      // R6 + R9: anticipated sync, then resync
      setup("R6", 1'b0, 1'b0, 15);
      frame(16, 4); frame(10, 4); frame(16, 4); frame(16, 4);
      check(err_anticipated == 1, "R6 early flag set", err_anticipated, 1);
      check(err_late == 0, "R6 late stays clear", err_late, 0);
      check(n_starts == 3, "R9 resync after early", n_starts, 3);

      // R7 + R9: late sync, then resync
      setup("R7", 1'b0, 1'b0, 15);
      frame(16, 8); frame(20, 8); frame(16, 8);
      check(err_late == 1, "R7 late flag set", err_late, 1);
      check(err_anticipated == 0, "R7 early stays clear", err_anticipated, 0);
      check(n_starts == 3, "R9 resync after late", n_starts, 3);

      // R10: flag holds, then clears on pulse
      repeat (5) @(posedge clk);
      #2;
      check(err_late == 1, "R10 flag sticky", err_late, 1);
      err_clr = 1'b1;
      @(posedge clk); #2 err_clr = 1'b0;
      check(err_late == 0, "R10 flag cleared", err_late, 0);

      // R10: set wins over a clear held high
      setup("R10", 1'b0, 1'b0, 15);
      @(posedge clk); #2 err_clr = 1'b1;
      frame(16, 4); frame(10, 4); frame(6, 4);
      @(posedge clk); #2 err_clr = 1'b0;
      check(n_ea_hi == 1, "R10 set beats clear", n_ea_hi, 1);

      @(posedge clk); #2;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule